// File: doc/BRIEF.md
# Radio Data Bit Buffer with Dual-Mode Serial Readout

This block sits behind a radio-data demodulator. It takes the recovered bit stream, one bit per strobe, and stores the bits in a 128-entry circular buffer. It then hands them out serially on one data pin, in one of two readout modes.

In master mode the block makes its own bit clock. Each bit is placed on the data pin half a bit period before the clock rises, so a receiver can sample it on the rising edge. The active-low status pin reports that the identification sync has been found. In slave mode an external controller drives the clock pin. Each rising edge it gives moves the next stored bit onto the data pin, and the status pin then means "data waiting".

Two select pins choose among master, slave, standby and a reserved test setting. Standby stops the oscillator through an enable output. An active-high clear input resets the identification state in every mode. In slave mode it also empties the buffer.

Top module: `rdbuf_readout`

## Requirements
- R1: Select pins {sel_test_i, sel_mode_i} decode 00 = master, 01 = slave, 10 = standby and 11 = reserved test. osc_en_o is low in standby only.
- R2: rdclk_oe_o is high in master mode only, and rdclk_o can be high only while rdclk_oe_o is high.
- R3: Bits leave the buffer in the order they arrived. In slave mode, the next bit appears on rd_data_o within 3 system clock cycles of a rising edge on rdclk_i.
- R4: In slave mode, stat_pull_o (1 = pin driven low) is high exactly while the buffer holds at least one bit. After reset it is low.
- R5: In slave mode, a rising edge on rdclk_i while the buffer is empty leaves rd_data_o unchanged.
- R6: The buffer holds 128 bits. A bit that arrives while it is full is dropped, and overflow_o goes high and stays high until a slave-mode clear.
- R7: In slave mode, clr_i high for one cycle empties the buffer, releases stat_pull_o, clears overflow_o and drives rd_data_o to 0.
- R8: In master mode, each bit is on rd_data_o for HALF_BIT cycles with rdclk_o low, then for HALF_BIT cycles with rdclk_o high. Bits follow each other with no gap, and rdclk_o stays low while the buffer is empty.
- R9: In master mode, stat_pull_o rises one cycle after sync_ok_i is seen high, and it stays high until clr_i.
- R10: In master mode, clr_i clears the sync indication and holds the stream stopped. Buffered bits are kept and stream out once clr_i falls.
- R11: In standby and test settings, incoming bits are not stored, rd_data_o and rdclk_o are 0, and stat_pull_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Active-high clear of the sync state, and in slave mode of the buffer |
| bit_valid_i | input | 1 | Strobe: bit_data_i holds a new demodulated bit |
| bit_data_i | input | 1 | Demodulated bit |
| sync_ok_i | input | 1 | Identification sync found |
| sel_test_i | input | 1 | Mode select, upper bit |
| sel_mode_i | input | 1 | Mode select, lower bit |
| rdclk_i | input | 1 | External read clock (slave mode) |
| rdclk_o | output | 1 | Generated bit clock (master mode) |
| rdclk_oe_o | output | 1 | Output enable for the clock pin |
| rd_data_o | output | 1 | Serial data out |
| stat_pull_o | output | 1 | Open-drain status: 1 pulls the pin low |
| osc_en_o | output | 1 | Oscillator enable, low in standby |
| overflow_o | output | 1 | Sticky buffer overflow |

## Verification
The assertions assume that the select pins change only between clock edges, and that rdclk_i changes slowly compared with the system clock. Each high or low phase must span at least three system cycles, so the synchroniser sees every edge exactly once. The stimulus meets both: it drives every input on the falling system edge, and it holds each phase of rdclk_i for three full cycles. The assertions also assume that pops come only from the reader of the active mode. The stimulus changes mode only while the master clock is idle or cleared.

// File: rtl/rdbuf_pkg.sv
// Package: shared types for the radio data bit buffer.
// Assumes: the mode encoding follows the select pins {test, mode}.
package rdbuf_pkg;

    typedef enum logic [1:0] {
        OP_MASTER  = 2'b00,
        OP_SLAVE   = 2'b01,
        OP_STANDBY = 2'b10,
        OP_TEST    = 2'b11
    } op_mode_t;

endpackage

// File: rtl/rdbuf_mode_dec.sv
// Module: decodes the two select pins into an operating mode and enables.
// Assumes: select pins are stable around the system clock edge.
module rdbuf_mode_dec
    import rdbuf_pkg::*;
(
    input  logic     sel_test_i,
    input  logic     sel_mode_i,
    output op_mode_t op_o,
    output logic     master_en_o,
    output logic     slave_en_o,
    output logic     osc_en_o
);

    // Map pin pair to mode and derive per-mode enables.
    always_comb begin
        op_o        = op_mode_t'({sel_test_i, sel_mode_i});
        master_en_o = (op_o == OP_MASTER);
        slave_en_o  = (op_o == OP_SLAVE);
        osc_en_o    = (op_o != OP_STANDBY);
    end

endmodule

// File: rtl/rdbuf_fifo.sv
// Module: single-bit circular buffer with sticky overflow.
// Assumes: pop_i is only raised by the reader of the active mode; a write
// arriving while full is dropped even if a pop happens in the same cycle.
module rdbuf_fifo #(
    parameter int DEPTH = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic wr_i,
    input  logic din_i,
    input  logic pop_i,
    output logic head_o,
    output logic empty_o,
    output logic full_o,
    output logic ovf_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [DEPTH-1:0] mem_q;
    logic [AW-1:0]    wptr_q;
    logic [AW-1:0]    rptr_q;
    logic [CW-1:0]    cnt_q;
    logic             ovf_q;
    logic             do_wr;
    logic             do_rd;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CNT_FULL);
    assign head_o  = mem_q[rptr_q];
    assign ovf_o   = ovf_q;
    assign do_wr   = wr_i && !full_o && !clr_i;
    assign do_rd   = pop_i && !empty_o && !clr_i;

    // Storage array: written at the write pointer, never reset.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem_q[wptr_q] <= din_i;
        end
    end

    // Pointers and fill count, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_wr) begin
                wptr_q <= (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
            end
            if (do_rd) begin
                rptr_q <= (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;
            end
            case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Sticky overflow: set on a dropped write, cleared only by clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            ovf_q <= 1'b0;
        end else if (wr_i && full_o) begin
            ovf_q <= 1'b1;
        end
    end

    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_FULL);

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_i) |=> ovf_q);

    a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && wr_i && !pop_i && !clr_i) |=> full_o);

    a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

endmodule

// File: rtl/rdbuf_slave_rd.sv
// Module: slave readout; synchronises the external read clock and pops one
// bit per rising edge onto a held data register.
// Assumes: each external clock phase lasts at least three system cycles.
module rdbuf_slave_rd (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clr_i,
    input  logic rdclk_i,
    input  logic empty_i,
    input  logic head_i,
    output logic pop_o,
    output logic data_o
);

    logic [2:0] sync_q;
    logic       rise;
    logic       data_q;

    assign rise   = sync_q[1] && !sync_q[2];
    assign pop_o  = en_i && !clr_i && rise && !empty_i;
    assign data_o = data_q;

    // Two-flop synchroniser plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], rdclk_i};
        end
    end

    // Output register: loads the buffer head on each accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            data_q <= 1'b0;
        end else if (pop_o) begin
            data_q <= head_i;
        end
    end

    a_r5_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && rise && empty_i && !clr_i) |=> $stable(data_o));

    a_r3_pop_loads: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |=> (data_o == $past(head_i)));

endmodule

// File: rtl/rdbuf_master_tx.sv
// Module: master readout; generates a bit clock and presents each bit a half
// period ahead of the rising clock edge, back to back while data remains.
// Assumes: HALF_BIT >= 1 system cycle.
module rdbuf_master_tx #(
    parameter int HALF_BIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clr_i,
    input  logic empty_i,
    input  logic head_i,
    output logic pop_o,
    output logic data_o,
    output logic bclk_o
);

    localparam int CW = $clog2(2 * HALF_BIT);
    localparam logic [CW-1:0] HALF_V = CW'(HALF_BIT);
    localparam logic [CW-1:0] LAST_V = CW'(2 * HALF_BIT - 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic          data_q;
    logic          start;
    logic          wrap;

    assign wrap   = run_q && (cnt_q == LAST_V);
    assign start  = en_i && !clr_i && !empty_i && (!run_q || wrap);
    assign pop_o  = start;
    assign data_o = data_q;
    assign bclk_o = run_q && (cnt_q >= HALF_V);

    // Bit-period sequencer: loads a bit at period start, stops when empty.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || clr_i) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (wrap) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (run_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Data register: holds the bit for the whole period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            data_q <= 1'b0;
        end else if (start) begin
            data_q <= head_i;
        end
    end

    a_r8_data_held_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_o && $past(bclk_o)) |-> $stable(data_o));

    a_r8_load_low: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |=> !bclk_o);

endmodule

// File: rtl/rdbuf_readout.sv
// Module: top of the bit buffer and readout. Routes the incoming bits into
// the buffer, selects master or slave readout, and drives the status pin.
// Assumes: mode changes happen while the master clock is idle or cleared.
module rdbuf_readout
    import rdbuf_pkg::*;
#(
    parameter int DEPTH    = 128,
    parameter int HALF_BIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic bit_valid_i,
    input  logic bit_data_i,
    input  logic sync_ok_i,
    input  logic sel_test_i,
    input  logic sel_mode_i,
    input  logic rdclk_i,
    output logic rdclk_o,
    output logic rdclk_oe_o,
    output logic rd_data_o,
    output logic stat_pull_o,
    output logic osc_en_o,
    output logic overflow_o
);

    op_mode_t op;
    logic     master_en;
    logic     slave_en;
    logic     fifo_head;
    logic     fifo_empty;
    logic     fifo_full;
    logic     m_pop;
    logic     s_pop;
    logic     m_data;
    logic     s_data;
    logic     m_bclk;
    logic     id_q;

    rdbuf_mode_dec u_dec (
        .sel_test_i  (sel_test_i),
        .sel_mode_i  (sel_mode_i),
        .op_o        (op),
        .master_en_o (master_en),
        .slave_en_o  (slave_en),
        .osc_en_o    (osc_en_o)
    );

    rdbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i && slave_en),
        .wr_i    (bit_valid_i && (master_en || slave_en)),
        .din_i   (bit_data_i),
        .pop_i   (m_pop || s_pop),
        .head_o  (fifo_head),
        .empty_o (fifo_empty),
        .full_o  (fifo_full),
        .ovf_o   (overflow_o)
    );

    rdbuf_master_tx #(.HALF_BIT(HALF_BIT)) u_mtx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (master_en),
        .clr_i   (clr_i),
        .empty_i (fifo_empty),
        .head_i  (fifo_head),
        .pop_o   (m_pop),
        .data_o  (m_data),
        .bclk_o  (m_bclk)
    );

    rdbuf_slave_rd u_srd (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (slave_en),
        .clr_i   (clr_i),
        .rdclk_i (rdclk_i),
        .empty_i (fifo_empty),
        .head_i  (fifo_head),
        .pop_o   (s_pop),
        .data_o  (s_data)
    );

    // Sticky sync indication, set by the sync flag, cleared by clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            id_q <= 1'b0;
        end else if (sync_ok_i && osc_en_o) begin
            id_q <= 1'b1;
        end
    end

    // Output routing per operating mode.
    always_comb begin
        rdclk_oe_o = master_en;
        rdclk_o    = m_bclk;
        case (op)
            OP_MASTER: begin
                rd_data_o   = m_data;
                stat_pull_o = id_q;
            end
            OP_SLAVE: begin
                rd_data_o   = s_data;
                stat_pull_o = !fifo_empty;
            end
            default: begin
                rd_data_o   = 1'b0;
                stat_pull_o = 1'b0;
            end
        endcase
    end

    a_r2_clk_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        rdclk_o |-> rdclk_oe_o);

    a_r11_no_clock_off_master: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !rdclk_o);

    a_r7_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !stat_pull_o);

    a_r3_single_reader: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_pop && s_pop));

    a_r6_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && bit_valid_i && slave_en && !clr_i) |=> overflow_o);

endmodule

// File: tb/rdbuf_readout_tb_top.sv
module rdbuf_readout_tb_top;

    localparam int HB    = 4;
    localparam int DEPTH = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_data = 1'b0;
    logic sync_ok = 1'b0;
    logic sel_test = 1'b0;
    logic sel_mode = 1'b1;
    logic rdclk_in = 1'b0;
    logic rdclk_out;
    logic rdclk_oe;
    logic rd_data;
    logic stat_pull;
    logic osc_en;
    logic overflow;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Mode table: {test, mode, expected osc_en, expected clock oe}
    localparam logic [3:0] MODE_VEC [4] = '{4'b0011, 4'b0110, 4'b1000, 4'b1110};

    // Master stream monitor state
    int   cap_n = 0;
    int   cap_bit [16];
    int   cap_gap [16];
    int   hi_len = 0;
    int   lo_len = 0;
    int   hi_last = 0;
    logic prev_s = 1'b0;

    always #10 clk = ~clk;

    rdbuf_readout #(.DEPTH(DEPTH), .HALF_BIT(HB)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr),
        .bit_valid_i (bit_valid),
        .bit_data_i  (bit_data),
        .sync_ok_i   (sync_ok),
        .sel_test_i  (sel_test),
        .sel_mode_i  (sel_mode),
        .rdclk_i     (rdclk_in),
        .rdclk_o     (rdclk_out),
        .rdclk_oe_o  (rdclk_oe),
        .rd_data_o   (rd_data),
        .stat_pull_o (stat_pull),
        .osc_en_o    (osc_en),
        .overflow_o  (overflow)
    );

    always @(negedge clk) begin
        if (rdclk_out && !prev_s) begin
            if (cap_n < 16) begin
                cap_bit[cap_n] = int'(rd_data);
                cap_gap[cap_n] = lo_len;
            end
            cap_n++;
        end
        if (!rdclk_out && prev_s) hi_last = hi_len;
        if (rdclk_out) hi_len = prev_s ? hi_len + 1 : 1;
        else           lo_len = prev_s ? 1 : lo_len + 1;
        prev_s = rdclk_out;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic pat(input int i);
        return logic'(((i % 3) == 0) ^ (((i / 8) % 2) == 1));
    endfunction

    task automatic push(input logic b);
        bit_data  = b;
        bit_valid = 1'b1;
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic slave_read(output logic b);
        rdclk_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        b = rd_data;
        rdclk_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_mode(input logic t, input logic m);
        sel_test = t;
        sel_mode = m;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic b;
        int   errs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state, slave mode
        check("R4", "status after reset", int'(stat_pull), 0);
        check("R6", "overflow after reset", int'(overflow), 0);
        check("R7", "data after reset", int'(rd_data), 0);
        check("R2", "clock after reset", int'(rdclk_out), 0);

        // Table walk over select pin settings
        for (int k = 0; k < 4; k++) begin
            set_mode(MODE_VEC[k][3], MODE_VEC[k][2]);
            @(negedge clk);
            check("R1", "osc enable", int'(osc_en), int'(MODE_VEC[k][1]));
            check("R2", "clock oe", int'(rdclk_oe), int'(MODE_VEC[k][0]));
        end

        // R11: standby ignores incoming bits
        set_mode(1'b1, 1'b0);
        @(negedge clk);
        push(1'b1); push(1'b1); push(1'b0);
        check("R11", "standby data", int'(rd_data), 0);
        check("R11", "standby clock", int'(rdclk_out), 0);
        check("R11", "standby status", int'(stat_pull), 0);
        set_mode(1'b0, 1'b1);
        @(negedge clk);
        check("R11", "nothing stored in standby", int'(stat_pull), 0);

        // R3/R4: slave readout order and ready
        push(1'b1); push(1'b0); push(1'b1);
        check("R4", "ready with data", int'(stat_pull), 1);
        slave_read(b); check("R3", "slave bit 0", int'(b), 1);
        slave_read(b); check("R3", "slave bit 1", int'(b), 0);
        check("R4", "ready with one left", int'(stat_pull), 1);
        slave_read(b); check("R3", "slave bit 2", int'(b), 1);
        check("R4", "ready released when empty", int'(stat_pull), 0);
        // R5: read when empty holds data
        slave_read(b); check("R5", "empty read holds", int'(b), 1);

        // R6: overflow
        for (int i = 0; i < DEPTH + 2; i++) push(pat(i));
        check("R6", "overflow set", int'(overflow), 1);
        errs = 0;
        for (int i = 0; i < DEPTH; i++) begin
            slave_read(b);
            if (b != pat(i)) errs++;
        end
        check("R6", "readback mismatches (R3 order)", errs, 0);
        check("R6", "empty after capacity read", int'(stat_pull), 0);
        check("R6", "overflow sticky", int'(overflow), 1);

        // R7: slave clear
        push(1'b1); push(1'b1);
        slave_read(b);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R7", "status after clear", int'(stat_pull), 0);
        check("R7", "overflow after clear", int'(overflow), 0);
        check("R7", "data after clear", int'(rd_data), 0);

        // R8: master stream
        push(1'b1); push(1'b0); push(1'b1); push(1'b1); push(1'b0);
        cap_n = 0;
        set_mode(1'b0, 1'b0);
        repeat (60) @(negedge clk);
        check("R8", "bits streamed", cap_n, 5);
        check("R8", "bit 0", cap_bit[0], 1);
        check("R8", "bit 1", cap_bit[1], 0);
        check("R8", "bit 2", cap_bit[2], 1);
        check("R8", "bit 3", cap_bit[3], 1);
        check("R8", "bit 4", cap_bit[4], 0);
        for (int i = 1; i < 5; i++) check("R8", "data lead before rise", cap_gap[i], HB);
        check("R8", "clock high length", hi_last, HB);
        check("R8", "idle clock low", int'(rdclk_out), 0);

        // R9: sync indication in master
        check("R9", "status before sync", int'(stat_pull), 0);
        sync_ok = 1'b1;
        @(negedge clk);
        sync_ok = 1'b0;
        check("R9", "status after sync", int'(stat_pull), 1);
        repeat (3) @(negedge clk);
        check("R9", "status sticky", int'(stat_pull), 1);

        // R10: master clear keeps buffer, stops stream
        set_mode(1'b0, 1'b1);
        @(negedge clk);
        push(1'b1); push(1'b1); push(1'b0);
        cap_n = 0;
        clr = 1'b1;
        set_mode(1'b0, 1'b0);
        repeat (20) @(negedge clk);
        check("R10", "no clock while cleared", cap_n, 0);
        check("R10", "sync cleared", int'(stat_pull), 0);
        clr = 1'b0;
        repeat (40) @(negedge clk);
        check("R10", "kept bits streamed", cap_n, 3);
        check("R10", "kept bit 0", cap_bit[0], 1);
        check("R10", "kept bit 1", cap_bit[1], 1);
        check("R10", "kept bit 2", cap_bit[2], 0);

        finished = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule